// File: doc/BRIEF.md
# Masked Vector Element Blend Unit

This block builds a 512-bit result by picking each element from one of two 512-bit source vectors. Bit j of a 64-bit selector mask controls element j. At run time the caller chooses four things: the element size (byte or 16-bit word), the active vector length (128, 256 or 512 bits), what a cleared mask bit produces (the first source's element or zeros), and an override that takes every active element from the second source whatever the mask holds.

Every result bit at or above the active length is driven to zero. The unit has one registered stage and accepts a new operation every cycle. The result register loads only when the input is marked valid, and it holds its value otherwise.

Top module: `vblend_unit`

## Requirements
- R1: With `elem_word`=0 (byte elements), element j is bits j*8+7..j*8 of each vector. If `sel_mask[j]`=1 that element comes from `src_b`.
- R2: With `elem_word`=1 (word elements), element j is bits j*16+15..j*16 of each vector. If `sel_mask[j]`=1 that element comes from `src_b`.
- R3: With `zero_mode`=0 and `no_mask`=0, an active element whose mask bit is 0 is copied from `src_a`.
- R4: With `zero_mode`=1 and `no_mask`=0, an active element whose mask bit is 0 is all zeros.
- R5: With `no_mask`=1, every active element comes from `src_b`, whatever `sel_mask` and `zero_mode` hold.
- R6: `len_sel` encodes the active length: 0 is 128 bits, 1 is 256 bits, 2 is 512 bits. Result bits from the active length up to bit 511 are zero.
- R7: `len_sel`=3 behaves exactly as `len_sel`=2 (512 bits).
- R8: Mask bits at or above the active element count have no effect on the result.
- R9: `out_valid` and `result` appear one clock after the edge that samples `in_valid`=1. Back-to-back operations complete one per cycle.
- R10: A cycle with `in_valid`=0 leaves `result` unchanged, and `out_valid` is 0 in the following cycle.
- R11: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present on the inputs |
| elem_word | input | 1 | 0 = byte elements, 1 = 16-bit word elements |
| len_sel | input | 2 | Active length code (0:128, 1:256, 2/3:512) |
| zero_mode | input | 1 | 0 = merge from `src_a`, 1 = zero unselected elements |
| no_mask | input | 1 | Take all active elements from `src_b` |
| sel_mask | input | 64 | Per-element selector, bit j for element j |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered blended vector |

## Verification
Each operation's result and valid flag are due exactly one rising edge after the edge that samples it. The bench drives inputs on the falling edge and samples one time unit after the next rising edge, so each check reads the register exactly as that single operation left it. Back-to-back operations are checked in successive cycles to show the one-per-cycle rate. A hold check changes the sources while `in_valid` is low and then compares `result` after the next edge.

// File: rtl/vblend_pkg.sv
package vblend_pkg;

  typedef enum logic [1:0] {
    LEN_128 = 2'd0,
    LEN_256 = 2'd1,
    LEN_512 = 2'd2,
    LEN_ALT = 2'd3
  } len_code_e;

  // number of active bytes for a length code; the spare code maps to full width
  function automatic logic [6:0] active_bytes(input logic [1:0] code);
    case (len_code_e'(code))
      LEN_128: active_bytes = 7'd16;
      LEN_256: active_bytes = 7'd32;
      default: active_bytes = 7'd64;
    endcase
  endfunction

  // selector bit index owning a given byte position
  function automatic int unsigned owner_elem(input int unsigned byte_idx, input logic word_mode);
    owner_elem = word_mode ? (byte_idx >> 1) : byte_idx;
  endfunction

endpackage

// File: rtl/vblend_ctrl.sv
module vblend_ctrl
  import vblend_pkg::*;
#(
  parameter int NBYTES = 64
) (
  input  logic              elem_word,
  input  logic [1:0]        len_sel,
  input  logic              no_mask,
  input  logic [NBYTES-1:0] sel_mask,
  output logic [NBYTES-1:0] byte_take_b,
  output logic [NBYTES-1:0] byte_active
);
  logic [6:0] act_cnt;

  always_comb act_cnt = active_bytes(len_sel);

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int unsigned BIDX = b;
    localparam int unsigned WIDX = BIDX >> 1;
    logic sel_bit;
    always_comb begin
      sel_bit        = elem_word ? sel_mask[WIDX] : sel_mask[BIDX];
      byte_take_b[b] = no_mask | sel_bit;
      byte_active[b] = (7'(BIDX) < act_cnt);
    end
  end
endmodule

// File: rtl/vblend_lane.sv
module vblend_lane #(
  parameter int LANE_W = 8
) (
  input  logic              take_b,
  input  logic              active,
  input  logic              zero_mode,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] y
);
  always_comb begin
    if (!active)       y = '0;
    else if (take_b)   y = b;
    else if (zero_mode) y = '0;
    else               y = a;
  end
endmodule

// File: rtl/vblend_unit.sv
module vblend_unit #(
  parameter int VEC_W  = 512,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      elem_word,
  input  logic [1:0]                len_sel,
  input  logic                      zero_mode,
  input  logic                      no_mask,
  input  logic [VEC_W/BYTE_W-1:0]   sel_mask,
  input  logic [VEC_W-1:0]          src_a,
  input  logic [VEC_W-1:0]          src_b,
  output logic                      out_valid,
  output logic [VEC_W-1:0]          result
);
  localparam int NBYTES = VEC_W / BYTE_W;

  logic [NBYTES-1:0] byte_take_b;
  logic [NBYTES-1:0] byte_active;
  logic [VEC_W-1:0]  blend_d;
  logic              load_en;

  vblend_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .elem_word   (elem_word),
    .len_sel     (len_sel),
    .no_mask     (no_mask),
    .sel_mask    (sel_mask),
    .byte_take_b (byte_take_b),
    .byte_active (byte_active)
  );

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    vblend_lane #(.LANE_W(BYTE_W)) u_lane (
      .take_b    (byte_take_b[i]),
      .active    (byte_active[i]),
      .zero_mode (zero_mode),
      .a         (src_a[i*BYTE_W +: BYTE_W]),
      .b         (src_b[i*BYTE_W +: BYTE_W]),
      .y         (blend_d[i*BYTE_W +: BYTE_W])
    );
  end

  assign load_en = in_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (load_en) result <= blend_d;
    end
  end
endmodule

// File: rtl/vblend_chk.sv
module vblend_chk #(
  parameter int VEC_W  = 512,
  parameter int NBYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        len_sel,
  input logic              zero_mode,
  input logic              no_mask,
  input logic [NBYTES-1:0] sel_mask,
  input logic [VEC_W-1:0]  src_a,
  input logic [VEC_W-1:0]  src_b,
  input logic [NBYTES-1:0] byte_active,
  input logic              out_valid,
  input logic [VEC_W-1:0]  result
);
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R10
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result)); // R10
  AST_UPPER_ZERO_128: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_sel == 2'd0) |=> (result[VEC_W-1:128] == '0)); // R6
  AST_UPPER_ZERO_256: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_sel == 2'd1) |=> (result[VEC_W-1:256] == '0)); // R6
  AST_OVERRIDE_FULL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && no_mask && len_sel[1]) |=> (result == $past(src_b))); // R5
  AST_MERGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !no_mask && !zero_mode && sel_mask == '0 && len_sel[1])
      |=> (result == $past(src_a))); // R3
  AST_ZERO_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !no_mask && zero_mode && sel_mask == '0) |=> (result == '0)); // R4
  AST_ACTIVE_SPAN: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ($countones(byte_active) == 16 || $countones(byte_active) == 32
                  || $countones(byte_active) == 64)); // R7
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0)); // R11
endmodule

bind vblend_unit vblend_chk #(.VEC_W(VEC_W), .NBYTES(NBYTES)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .len_sel     (len_sel),
  .zero_mode   (zero_mode),
  .no_mask     (no_mask),
  .sel_mask    (sel_mask),
  .src_a       (src_a),
  .src_b       (src_b),
  .byte_active (byte_active),
  .out_valid   (out_valid),
  .result      (result)
);

// File: tb/vblend_unit_bench.sv
module vblend_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic         elem_word;
  logic [1:0]   len_sel;
  logic         zero_mode;
  logic         no_mask;
  logic [63:0]  sel_mask;
  logic [511:0] src_a;
  logic [511:0] src_b;
  logic         out_valid;
  logic [511:0] result;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vblend_unit u_vblend_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .elem_word(elem_word),
    .len_sel(len_sel), .zero_mode(zero_mode), .no_mask(no_mask),
    .sel_mask(sel_mask), .src_a(src_a), .src_b(src_b),
    .out_valid(out_valid), .result(result)
  );

  always #4 clk = ~clk;

  function automatic logic [511:0] rand_vec();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  // independent model: walk elements of the chosen size up to the active width
  function automatic logic [511:0] model(input logic w, input logic [1:0] ls,
      input logic zm, input logic nm, input logic [63:0] m,
      input logic [511:0] a, input logic [511:0] b);
    logic [511:0] r;
    int bits;
    r = '0;
    bits = (ls == 2'd0) ? 128 : (ls == 2'd1) ? 256 : 512;
    if (!w) begin
      for (int e = 0; e < bits / 8; e++)
        r[e*8 +: 8] = (nm || m[e]) ? b[e*8 +: 8] : (zm ? 8'h00 : a[e*8 +: 8]);
    end else begin
      for (int e = 0; e < bits / 16; e++)
        r[e*16 +: 16] = (nm || m[e]) ? b[e*16 +: 16] : (zm ? 16'h0000 : a[e*16 +: 16]);
    end
    return r;
  endfunction

  task automatic check_vec(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] ls, input logic zm,
      input logic nm, input logic [63:0] m, input logic [511:0] a, input logic [511:0] b);
    @(negedge clk);
    in_valid = 1'b1; elem_word = w; len_sel = ls; zero_mode = zm;
    no_mask = nm; sel_mask = m; src_a = a; src_b = b;
  endtask

  // one operation: drive, let one edge capture it, compare
  task automatic run_op(input string req, input logic w, input logic [1:0] ls,
      input logic zm, input logic nm, input logic [63:0] m,
      input logic [511:0] a, input logic [511:0] b, input logic [511:0] exp);
    drive(w, ls, zm, nm, m, a, b);
    @(posedge clk); #1;
    check_bit(req, out_valid, 1'b1);
    check_vec(req, result, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; elem_word = 1'b0; len_sel = 2'd2;
    zero_mode = 1'b0; no_mask = 1'b1; sel_mask = '1;
    src_a = rand_vec(); src_b = rand_vec();
    repeat (3) @(posedge clk);
    #1;
    check_bit("R11", out_valid, 1'b0);
    check_vec("R11", result, '0);
    @(negedge clk);
    rst = 1'b0; in_valid = 1'b0;
  endtask

  task automatic t_byte_merge();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    logic [63:0] m = {$urandom, $urandom};
    run_op("R1 R3", 1'b0, 2'd2, 1'b0, 1'b0, m, a, b, model(1'b0, 2'd2, 1'b0, 1'b0, m, a, b));
    // alternating pattern: even bytes from src_a, odd from src_b
    m = 64'hAAAA_AAAA_AAAA_AAAA;
    run_op("R1", 1'b0, 2'd2, 1'b0, 1'b0, m, a, b, model(1'b0, 2'd2, 1'b0, 1'b0, m, a, b));
  endtask

  task automatic t_word_modes();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    logic [63:0] m = {$urandom, $urandom};
    run_op("R2 R3", 1'b1, 2'd2, 1'b0, 1'b0, m, a, b, model(1'b1, 2'd2, 1'b0, 1'b0, m, a, b));
    run_op("R2 R4", 1'b1, 2'd1, 1'b1, 1'b0, m, a, b, model(1'b1, 2'd1, 1'b1, 1'b0, m, a, b));
    m = 64'h0000_0000_5555_5555;
    run_op("R2", 1'b1, 2'd2, 1'b0, 1'b0, m, a, b, model(1'b1, 2'd2, 1'b0, 1'b0, m, a, b));
  endtask

  task automatic t_zeroing();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    logic [63:0] m = {$urandom, $urandom};
    run_op("R4", 1'b0, 2'd2, 1'b1, 1'b0, m, a, b, model(1'b0, 2'd2, 1'b1, 1'b0, m, a, b));
    run_op("R4", 1'b0, 2'd2, 1'b1, 1'b0, 64'h0, a, b, '0);
  endtask

  task automatic t_override();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    run_op("R5", 1'b0, 2'd2, 1'b1, 1'b1, 64'h0, a, b, b);
    run_op("R5 R6", 1'b1, 2'd0, 1'b0, 1'b1, 64'h0, a, b, {384'h0, b[127:0]});
  endtask

  task automatic t_lengths();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    logic [63:0] m = {$urandom, $urandom};
    run_op("R6", 1'b0, 2'd0, 1'b0, 1'b0, m, a, b, model(1'b0, 2'd0, 1'b0, 1'b0, m, a, b));
    run_op("R6", 1'b0, 2'd1, 1'b0, 1'b0, m, a, b, model(1'b0, 2'd1, 1'b0, 1'b0, m, a, b));
    run_op("R7", 1'b0, 2'd3, 1'b0, 1'b0, m, a, b, model(1'b0, 2'd2, 1'b0, 1'b0, m, a, b));
    run_op("R7", 1'b1, 2'd3, 1'b1, 1'b0, m, a, b, model(1'b1, 2'd2, 1'b1, 1'b0, m, a, b));
  endtask

  task automatic t_upper_mask();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    // 128-bit bytes: bits 16..63 set must not matter
    run_op("R8", 1'b0, 2'd0, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_0000, a, b, {384'h0, a[127:0]});
    // 256-bit words: 16 elements, bits 16..63 set must not matter
    run_op("R8", 1'b1, 2'd1, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_0000, a, b, {256'h0, a[255:0]});
  endtask

  task automatic t_stream();
    logic [511:0] a [4];
    logic [63:0]  m [4];
    logic [511:0] b = rand_vec();
    for (int k = 0; k < 4; k++) begin
      a[k] = rand_vec();
      m[k] = {$urandom, $urandom};
    end
    for (int k = 0; k < 4; k++)
      run_op("R9", k[0], 2'(k % 3), k[1], 1'b0, m[k], a[k], b,
             model(k[0], 2'(k % 3), k[1], 1'b0, m[k], a[k], b));
  endtask

  task automatic t_hold();
    logic [511:0] a = rand_vec();
    logic [511:0] b = rand_vec();
    logic [511:0] exp = model(1'b0, 2'd2, 1'b0, 1'b0, 64'h0F0F, a, b);
    run_op("R10", 1'b0, 2'd2, 1'b0, 1'b0, 64'h0F0F, a, b, exp);
    @(negedge clk);
    in_valid = 1'b0; src_a = rand_vec(); src_b = rand_vec(); no_mask = 1'b1;
    @(posedge clk); #1;
    check_bit("R10", out_valid, 1'b0);
    check_vec("R10", result, exp);
    @(posedge clk); #1;
    check_vec("R10", result, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_byte_merge();
    t_word_modes();
    t_zeroing();
    t_override();
    t_lengths();
    t_upper_mask();
    t_stream();
    t_hold();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule